// File: doc/BRIEF.md
# Shared Interrupt Fan-Out Hub

This block takes one external interrupt request and turns it into one interrupt line per processor (three by default). The request is first brought into the clock domain through a flop chain, then an edge detector (rising or falling, chosen by a parameter) starts a new round. At the start of a round every processor's pending flag is set together, so every processor sees the event.

Each processor owns a single-register slave port. Reading it returns that processor's own pending flag, the pending flags of all processors, and a sticky overrun flag. Writing a 1 to bit 0 acknowledges the interrupt for that processor only. An acknowledge never drops or hides the interrupt of any other processor. The upstream source gets its clear pulse only once the last outstanding processor has acknowledged. At that point the hub re-arms, and the next edge again interrupts every processor.

Top module: `irq_fanout_hub`

## Requirements
- R1: A synchronous active-high reset clears every pending flag, every overrun flag and the source-clear output. After reset all interrupt lines and all read words are zero.
- R2: With the rising-edge variant and two synchronizer stages, a 0-to-1 change of the input sets all pending flags and all interrupt lines. If the input is changed just before clock edge k, the lines are high after edge k+2 and still low after edge k+1. Holding the input at one level starts nothing further.
- R3: With the falling-edge variant, a 1-to-0 change starts a round with the same latency, and a 0-to-1 change is ignored.
- R4: Read word of port i: bit 0 is port i's own pending flag, bits NUM_CPU:1 hold the pending flags of processors 0 to NUM_CPU-1 in ascending order, bit NUM_CPU+1 (bit 4 by default) is port i's overrun flag, and all higher bits read 0.
- R5: A write to port i with write-data bit 0 equal to 1 clears pending flag i and overrun flag i after the next clock edge. The flags of the other ports are left unchanged.
- R6: A write with write-data bit 0 equal to 0 changes no flag and no interrupt line.
- R7: The source clear is a one-cycle pulse. It is high in the cycle after the clock edge that accepts the last outstanding acknowledge, and it is never high while any processor is still pending.
- R8: Acknowledges from several ports in the same cycle are all accepted. When they complete the round, exactly one source-clear pulse results.
- R9: An edge that arrives while any flag is pending sets the overrun flag of every port and starts no new round. That edge is not replayed after the round completes.
- R10: After a round completes, the next edge sets all pending flags again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 1 | Asynchronous shared interrupt request |
| cpu_wr | input | NUM_CPU | Write strobe, one bit per port |
| cpu_wdata0 | input | NUM_CPU | Write-data bit 0, one bit per port |
| cpu_rdata | output | NUM_CPU*DATA_W | Read words, port i in bits i*DATA_W +: DATA_W |
| cpu_irq | output | NUM_CPU | Interrupt line per processor |
| src_clear | output | 1 | One-cycle clear pulse to the upstream source |

## Verification
The bench builds the hub twice, both with three processors, two synchronizer stages and 8-bit read words. One copy uses the rising-edge variant and carries the acknowledge orderings, the overrun case and re-arming. The other uses the falling-edge variant, which makes the opposite polarity reachable. It also covers the case where the input already sits high when reset is released, and shows that this produces no spurious round. With three ports, both a partial simultaneous acknowledge and a full one can be exercised.

// File: rtl/irqfan_pkg.sv
package irqfan_pkg;
   localparam int OWN_BIT = 0;
   localparam int ALL_LSB = 1;
   function automatic int ovr_bit(input int n_cpu);
      return n_cpu + 1;
   endfunction
endpackage

// File: rtl/irqfan_edge_sense.sv
module irqfan_edge_sense #(
   parameter int SYNC_STAGES = 2,
   parameter bit RISING      = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic edge_hit
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic                   last_q;
   logic                   now_lvl;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain  <= '0;
         last_q <= 1'b0;
      end else begin
         chain  <= {chain[SYNC_STAGES-2:0], async_in};
         last_q <= chain[SYNC_STAGES-1];
      end
   end

   assign now_lvl = chain[SYNC_STAGES-1];

   if (RISING) begin : g_rise
      assign edge_hit = now_lvl & ~last_q;
   end else begin : g_fall
      assign edge_hit = ~now_lvl & last_q;
   end

   // an edge lasts one cycle only
   assert_edge_single_R2: assert property (@(posedge clk) disable iff (rst)
      edge_hit |=> !edge_hit);
endmodule

// File: rtl/irqfan_channel.sv
module irqfan_channel
   import irqfan_pkg::*;
#(
   parameter int NUM_CPU = 3,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic               ovr_evt,
   input  logic               ack,
   input  logic [NUM_CPU-1:0] all_pend,
   output logic               pend,
   output logic               ovr,
   output logic [DATA_W-1:0]  rword
);
   always_ff @(posedge clk) begin
      if (rst) begin
         pend <= 1'b0;
         ovr  <= 1'b0;
      end else begin
         if (start)    pend <= 1'b1;
         else if (ack) pend <= 1'b0;
         if (ovr_evt)  ovr  <= 1'b1;
         else if (ack) ovr  <= 1'b0;
      end
   end

   always_comb begin
      rword                            = '0;
      rword[OWN_BIT]                   = pend;
      rword[ALL_LSB +: NUM_CPU]        = all_pend;
      rword[ovr_bit(NUM_CPU)]          = ovr;
   end

   assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (rst)
      pend && !ack |=> pend);
   assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (rst)
      !pend && !start |=> !pend);
   assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      ovr && !ack |=> ovr);
endmodule

// File: rtl/irqfan_round.sv
module irqfan_round #(
   parameter int NUM_CPU = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               edge_hit,
   input  logic [NUM_CPU-1:0] pend,
   input  logic [NUM_CPU-1:0] ack,
   output logic               start,
   output logic               ovr_evt,
   output logic               src_clear
);
   logic busy;
   logic last_ack;

   assign busy     = |pend;
   assign start    = edge_hit & ~busy;
   assign ovr_evt  = edge_hit & busy;
   assign last_ack = busy & ((pend & ~ack) == '0);

   always_ff @(posedge clk) begin
      if (rst) src_clear <= 1'b0;
      else     src_clear <= last_ack;
   end

   assert_clear_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
      src_clear |=> !src_clear);
   assert_clear_after_all_R7: assert property (@(posedge clk) disable iff (rst)
      src_clear |-> pend == '0);
   assert_round_sets_all_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> &pend);
   assert_no_round_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
      edge_hit && busy |=> $countones(pend) <= $countones($past(pend)));
endmodule

// File: rtl/irq_fanout_hub.sv
module irq_fanout_hub
   import irqfan_pkg::*;
#(
   parameter int NUM_CPU     = 3,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit RISING      = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      irq_src,
   input  logic [NUM_CPU-1:0]        cpu_wr,
   input  logic [NUM_CPU-1:0]        cpu_wdata0,
   output logic [NUM_CPU*DATA_W-1:0] cpu_rdata,
   output logic [NUM_CPU-1:0]        cpu_irq,
   output logic                      src_clear
);
   localparam int FIELD_W = NUM_CPU + 2;

   if (NUM_CPU < 1) begin : g_bad_cpu
      $error("NUM_CPU must be at least 1");
   end
   if (DATA_W < FIELD_W) begin : g_bad_width
      $error("DATA_W too narrow for the read word");
   end

   logic               edge_hit;
   logic               start;
   logic               ovr_evt;
   logic [NUM_CPU-1:0] pend;
   logic [NUM_CPU-1:0] ovr;
   logic [NUM_CPU-1:0] ack;

   assign ack     = cpu_wr & cpu_wdata0;
   assign cpu_irq = pend;

   irqfan_edge_sense #(.SYNC_STAGES(SYNC_STAGES), .RISING(RISING)) u_edge (
      .clk(clk), .rst(rst), .async_in(irq_src), .edge_hit(edge_hit));

   irqfan_round #(.NUM_CPU(NUM_CPU)) u_round (
      .clk(clk), .rst(rst), .edge_hit(edge_hit), .pend(pend), .ack(ack),
      .start(start), .ovr_evt(ovr_evt), .src_clear(src_clear));

   for (genvar i = 0; i < NUM_CPU; i++) begin : g_chan
      irqfan_channel #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_chan (
         .clk(clk), .rst(rst), .start(start), .ovr_evt(ovr_evt),
         .ack(ack[i]), .all_pend(pend), .pend(pend[i]), .ovr(ovr[i]),
         .rword(cpu_rdata[i*DATA_W +: DATA_W]));
   end

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (pend == '0) && (ovr == '0) && !src_clear);
endmodule

// File: tb/irq_fanout_hub_test.sv
module irq_fanout_hub_test;
   localparam int N = 3;
   localparam int W = 8;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           irq_r = 1'b0;
   logic           irq_f = 1'b1;
   logic [N-1:0]   wr = '0;
   logic [N-1:0]   wd = '0;
   logic [N*W-1:0] rd_r, rd_f;
   logic [N-1:0]   line_r, line_f;
   logic           clr_r, clr_f;
   int             total = 0;
   int             bad = 0;

   always #2 clk = ~clk;

   irq_fanout_hub #(.NUM_CPU(N), .DATA_W(W), .SYNC_STAGES(2), .RISING(1'b1)) uut (
      .clk(clk), .rst(rst), .irq_src(irq_r), .cpu_wr(wr), .cpu_wdata0(wd),
      .cpu_rdata(rd_r), .cpu_irq(line_r), .src_clear(clr_r));

   irq_fanout_hub #(.NUM_CPU(N), .DATA_W(W), .SYNC_STAGES(2), .RISING(1'b0)) uut_fall (
      .clk(clk), .rst(rst), .irq_src(irq_f), .cpu_wr('0), .cpu_wdata0('0),
      .cpu_rdata(rd_f), .cpu_irq(line_f), .src_clear(clr_f));

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write(input logic [N-1:0] strobe, input logic [N-1:0] bit0);
      wr = strobe;
      wd = bit0;
      tick(1);
      wr = '0;
      wd = '0;
   endtask

   task automatic t_reset;
      check("R1 lines", line_r, 0);
      check("R1 clear", clr_r, 0);
      check("R1 rdata", rd_r, 0);
      check("R1 fall lines", line_f, 0);
   endtask

   task automatic t_edge;
      irq_r = 1'b1;
      tick(2);
      check("R2 not yet", line_r, 3'b000);
      tick(1);
      check("R2 lines set", line_r, 3'b111);
      check("R4 word0", rd_r[0 +: W], 8'h0F);
      check("R4 word2", rd_r[2*W +: W], 8'h0F);
      tick(10);
      check("R2 level hold", rd_r, {3{8'h0F}});
   endtask

   task automatic t_write0;
      write(3'b111, 3'b000);
      check("R6 lines", line_r, 3'b111);
      check("R6 rdata", rd_r, {3{8'h0F}});
      check("R6 clear", clr_r, 0);
   endtask

   task automatic t_ack_order;
      write(3'b010, 3'b010);
      check("R5 lines", line_r, 3'b101);
      check("R4 word0 partial", rd_r[0 +: W], 8'h0B);
      check("R4 word1 partial", rd_r[W +: W], 8'h0A);
      check("R7 early clear", clr_r, 0);
      write(3'b001, 3'b001);
      check("R5 lines two", line_r, 3'b100);
      check("R7 early clear two", clr_r, 0);
      write(3'b100, 3'b100);
      check("R7 lines done", line_r, 3'b000);
      check("R7 pulse", clr_r, 1);
      tick(1);
      check("R7 pulse ends", clr_r, 0);
   endtask

   task automatic t_rearm;
      irq_r = 1'b0;
      tick(4);
      check("R10 falling ignored", line_r, 3'b000);
      irq_r = 1'b1;
      tick(3);
      check("R10 rearmed", line_r, 3'b111);
   endtask

   task automatic t_overrun;
      irq_r = 1'b0;
      tick(4);
      irq_r = 1'b1;
      tick(4);
      check("R9 overrun words", rd_r, {3{8'h1F}});
      check("R9 no new round", line_r, 3'b111);
      write(3'b001, 3'b001);
      check("R9 word0 ovr cleared", rd_r[0 +: W], 8'h0C);
      check("R9 word1 ovr kept", rd_r[W +: W], 8'h1D);
      write(3'b110, 3'b110);
      check("R8 lines done", line_r, 3'b000);
      check("R8 pulse", clr_r, 1);
      check("R9 all clear", rd_r, 0);
      tick(1);
      check("R8 single pulse", clr_r, 0);
      tick(5);
      check("R9 no replay", line_r, 3'b000);
      check("R8 no second pulse", clr_r, 0);
   endtask

   task automatic t_all_at_once;
      irq_r = 1'b0;
      tick(4);
      irq_r = 1'b1;
      tick(3);
      check("R10 round again", line_r, 3'b111);
      write(3'b111, 3'b111);
      check("R8 simultaneous lines", line_r, 3'b000);
      check("R8 simultaneous pulse", clr_r, 1);
      tick(1);
      check("R8 simultaneous once", clr_r, 0);
   endtask

   task automatic t_falling;
      check("R3 no spurious", line_f, 3'b000);
      irq_f = 1'b0;
      tick(2);
      check("R3 not yet", line_f, 3'b000);
      tick(1);
      check("R3 fall sets", line_f, 3'b111);
      irq_f = 1'b1;
      tick(4);
      check("R3 rise ignored", rd_f, {3{8'h0F}});
   endtask

   initial begin
      #(200000 * 4);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(3);
      rst = 1'b0;
      tick(4);
      t_reset();
      t_edge();
      t_write0();
      t_ack_order();
      t_rearm();
      t_overrun();
      t_all_at_once();
      t_falling();
      irq_r = 1'b1;
      tick(3);
      rst = 1'b1;
      irq_r = 1'b0;
      tick(3);
      rst = 1'b0;
      tick(1);
      check("R1 reset mid round", line_r, 0);
      check("R1 reset fall inst", line_f, 0);
      check("R1 reset rdata", rd_f, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule